// File: doc/BRIEF.md
# Bit-Test Long-Jump Branch Unit

This block produces the next program counter for the long-jump instructions of a small controller whose instruction memory is addressed with 16 bits. It has three jump forms:

- A conditional form picks one bit of an 8-bit register operand and compares it with a polarity bit carried in the instruction. When the two agree, the jump goes to a 16-bit absolute target.
- An absolute form always jumps to the 16-bit target.
- An indexed form always jumps to the address held in one of four 16-bit index registers. A 2-bit select field picks the register.

The result is captured in a register on an execute strobe. Instruction decode, the register file and fetch live outside the block.

The absolute forms occupy two instruction words and the indexed form occupies one. A conditional jump that is not taken therefore moves the PC on by two. When no jump form is active, the PC moves on by one. All fall-through arithmetic wraps modulo 2^16. The block has no flag outputs, so no form of the jump can change a status flag.

Top module: `bjmp_unit`

## Requirements
- R1: While rst_ni is low, next_pc_o is 0x0000 and taken_o is 0.
- R2: With form_i = 2'b01 (conditional), the jump is taken when bit bit_pos_i of reg_val_i equals polarity_i. In that case next_pc_o becomes abs_tgt_i and taken_o becomes 1.
- R3: bit_pos_i = 0 tests the least significant bit of reg_val_i and bit_pos_i = 7 tests the most significant bit. Every value from 0 to 7 selects that bit.
- R4: With form_i = 2'b01, when the tested bit differs from polarity_i, next_pc_o becomes cur_pc_i + 2 and taken_o becomes 0.
- R5: With form_i = 2'b10 (absolute), next_pc_o becomes abs_tgt_i for any value from 0x0000 to 0xFFFF, and taken_o becomes 1.
- R6: With form_i = 2'b11 (indexed), next_pc_o becomes slot idx_sel_i of idx_regs_i, and taken_o becomes 1. Slot k occupies bits [16k+15:16k].
- R7: With form_i = 2'b00 (no jump), next_pc_o becomes cur_pc_i + 1 and taken_o becomes 0.
- R8: Outputs update one clock edge after exec_en_i is sampled high. While exec_en_i is low, both outputs hold their values whatever the other inputs do.
- R9: Fall-through addresses wrap modulo 2^16. For example, 0xFFFF + 2 gives 0x0001 and 0xFFFF + 1 gives 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_en_i | input | 1 | Execute strobe; updates the outputs |
| form_i | input | 2 | Jump form: 00 none, 01 conditional, 10 absolute, 11 indexed |
| reg_val_i | input | 8 | Register operand under test |
| bit_pos_i | input | 3 | Bit position tested in reg_val_i |
| polarity_i | input | 1 | Required value of the tested bit |
| abs_tgt_i | input | 16 | Absolute jump target |
| idx_regs_i | input | 64 | Four packed 16-bit index registers |
| idx_sel_i | input | 2 | Index register select |
| cur_pc_i | input | 16 | Current program counter |
| next_pc_o | output | 16 | Registered next program counter |
| taken_o | output | 1 | Registered jump-taken flag |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit register operand and four index slots. These defaults let it reach every one of the eight bit positions under both polarities and each of the four index slots. They also bring within reach the top of the address space, so targets of 0x0000 and 0xFFFF and the modulo-2^16 wrap of both fall-through increments can be tested.

// File: rtl/bjmp_pkg.sv
package bjmp_pkg;
  typedef enum logic [1:0] {
    FORM_NONE = 2'b00,
    FORM_COND = 2'b01,
    FORM_ABS  = 2'b10,
    FORM_IDX  = 2'b11
  } jump_form_e;

  // instruction lengths in words
  localparam int unsigned SEQ_LEN = 1;
  localparam int unsigned ABS_LEN = 2;
  localparam int unsigned IDX_LEN = 1;
endpackage

// File: rtl/bjmp_bit_test.sv
module bjmp_bit_test #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned POS_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              pol_i,
  output logic              match_o
);
  logic [DATA_W-1:0] hit;
  logic              bit_sel;

  for (genvar g = 0; g < DATA_W; g++) begin : g_hit
    assign hit[g] = (pos_i == POS_W'(g)) & val_i[g];
  end

  assign bit_sel = |hit;
  assign match_o = (bit_sel == pol_i);
endmodule

// File: rtl/bjmp_idx_sel.sv
module bjmp_idx_sel #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned NUM_IDX = 4,
  localparam int unsigned SEL_W  = (NUM_IDX > 1) ? $clog2(NUM_IDX) : 1
) (
  input  logic [NUM_IDX*ADDR_W-1:0] regs_i,
  input  logic [SEL_W-1:0]          sel_i,
  output logic [ADDR_W-1:0]         tgt_o
);
  logic [ADDR_W-1:0] masked [NUM_IDX];

  for (genvar g = 0; g < NUM_IDX; g++) begin : g_mask
    assign masked[g] = (sel_i == SEL_W'(g)) ? regs_i[g*ADDR_W +: ADDR_W] : '0;
  end

  always_comb begin
    tgt_o = '0;
    for (int i = 0; i < NUM_IDX; i++) tgt_o |= masked[i];
  end
endmodule

// File: rtl/bjmp_target_calc.sv
module bjmp_target_calc
  import bjmp_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  jump_form_e        form_i,
  input  logic              match_i,
  input  logic [ADDR_W-1:0] abs_tgt_i,
  input  logic [ADDR_W-1:0] idx_tgt_i,
  input  logic [ADDR_W-1:0] cur_pc_i,
  output logic [ADDR_W-1:0] nxt_o,
  output logic              take_o
);
  logic [ADDR_W-1:0] pc_seq, pc_abs_skip;

  assign pc_seq      = cur_pc_i + ADDR_W'(SEQ_LEN);
  assign pc_abs_skip = cur_pc_i + ADDR_W'(ABS_LEN);

  always_comb begin
    nxt_o  = pc_seq;
    take_o = 1'b0;
    unique case (form_i)
      FORM_COND: begin
        take_o = match_i;
        nxt_o  = match_i ? abs_tgt_i : pc_abs_skip;
      end
      FORM_ABS: begin
        take_o = 1'b1;
        nxt_o  = abs_tgt_i;
      end
      FORM_IDX: begin
        take_o = 1'b1;
        nxt_o  = idx_tgt_i;
      end
      default: begin
        take_o = 1'b0;
        nxt_o  = pc_seq;
      end
    endcase
  end
endmodule

// File: rtl/bjmp_unit.sv
module bjmp_unit
  import bjmp_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NUM_IDX = 4,
  localparam int unsigned POS_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1,
  localparam int unsigned SEL_W  = (NUM_IDX > 1) ? $clog2(NUM_IDX) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      exec_en_i,
  input  logic [1:0]                form_i,
  input  logic [DATA_W-1:0]         reg_val_i,
  input  logic [POS_W-1:0]          bit_pos_i,
  input  logic                      polarity_i,
  input  logic [ADDR_W-1:0]         abs_tgt_i,
  input  logic [NUM_IDX*ADDR_W-1:0] idx_regs_i,
  input  logic [SEL_W-1:0]          idx_sel_i,
  input  logic [ADDR_W-1:0]         cur_pc_i,
  output logic [ADDR_W-1:0]         next_pc_o,
  output logic                      taken_o
);
  jump_form_e        form;
  logic              match;
  logic [ADDR_W-1:0] idx_tgt, nxt;
  logic              take;

  assign form = jump_form_e'(form_i);

  bjmp_bit_test #(.DATA_W(DATA_W)) u_bit_test (
    .val_i   (reg_val_i),
    .pos_i   (bit_pos_i),
    .pol_i   (polarity_i),
    .match_o (match)
  );

  bjmp_idx_sel #(.ADDR_W(ADDR_W), .NUM_IDX(NUM_IDX)) u_idx_sel (
    .regs_i (idx_regs_i),
    .sel_i  (idx_sel_i),
    .tgt_o  (idx_tgt)
  );

  bjmp_target_calc #(.ADDR_W(ADDR_W)) u_calc (
    .form_i    (form),
    .match_i   (match),
    .abs_tgt_i (abs_tgt_i),
    .idx_tgt_i (idx_tgt),
    .cur_pc_i  (cur_pc_i),
    .nxt_o     (nxt),
    .take_o    (take)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_pc_o <= '0;
      taken_o   <= 1'b0;
    end else if (exec_en_i) begin
      next_pc_o <= nxt;
      taken_o   <= take;
    end
  end

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) reset_val_chk: assert (next_pc_o == '0 && !taken_o);
  end

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_en_i |=> $stable(next_pc_o) && $stable(taken_o));

  // R5
  abs_jump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_en_i && form_i == 2'b10 |=> next_pc_o == $past(abs_tgt_i) && taken_o);

  // R7
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_en_i && form_i == 2'b00 |=>
      next_pc_o == ADDR_W'($past(cur_pc_i) + ADDR_W'(1)) && !taken_o);

  // R4
  cond_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_en_i && form_i == 2'b01 && (reg_val_i[bit_pos_i] != polarity_i) |=>
      next_pc_o == ADDR_W'($past(cur_pc_i) + ADDR_W'(2)) && !taken_o);

  // R2
  cond_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_en_i && form_i == 2'b01 && (reg_val_i[bit_pos_i] == polarity_i) |=>
      next_pc_o == $past(abs_tgt_i) && taken_o);

  // R6
  idx_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_en_i && form_i == 2'b11 |=> taken_o);
endmodule

// File: tb/bjmp_unit_tb.sv
module bjmp_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_en = 1'b0;
  logic [1:0]  form = 2'b00;
  logic [7:0]  reg_val = '0;
  logic [2:0]  bit_pos = '0;
  logic        pol = 1'b0;
  logic [15:0] abs_tgt = '0;
  logic [63:0] idx_regs = '0;
  logic [1:0]  idx_sel = '0;
  logic [15:0] cur_pc = '0;
  logic [15:0] next_pc;
  logic        taken;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bjmp_unit u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .exec_en_i  (exec_en),
    .form_i     (form),
    .reg_val_i  (reg_val),
    .bit_pos_i  (bit_pos),
    .polarity_i (pol),
    .abs_tgt_i  (abs_tgt),
    .idx_regs_i (idx_regs),
    .idx_sel_i  (idx_sel),
    .cur_pc_i   (cur_pc),
    .next_pc_o  (next_pc),
    .taken_o    (taken)
  );

  task automatic chk(string req, logic [15:0] exp_pc, logic exp_t);
    checks++;
    if (next_pc !== exp_pc || taken !== exp_t) begin
      errors++;
      $display("FAIL %s: pc=%h taken=%b expected pc=%h taken=%b",
               req, next_pc, taken, exp_pc, exp_t);
    end
  endtask

  // drive one executed instruction, sample one edge later
  task automatic run(logic [1:0] f, logic [7:0] rv, logic [2:0] p, logic s,
                     logic [15:0] tgt, logic [1:0] sel, logic [15:0] pc);
    @(negedge clk);
    form = f; reg_val = rv; bit_pos = p; pol = s;
    abs_tgt = tgt; idx_sel = sel; cur_pc = pc; exec_en = 1'b1;
    @(negedge clk);
    exec_en = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset", 16'h0000, 1'b0);
  endtask

  task automatic t_cond_taken();
    for (int p = 0; p < 8; p++) begin
      run(2'b01, 8'(1 << p), 3'(p), 1'b1, 16'(16'hA000 + p), 2'd0, 16'h0100);
      chk("R2/R3 cond taken pol=1", 16'(16'hA000 + p), 1'b1);
      run(2'b01, ~8'(1 << p), 3'(p), 1'b0, 16'(16'hB000 + p), 2'd0, 16'h0200);
      chk("R2/R3 cond taken pol=0", 16'(16'hB000 + p), 1'b1);
    end
  endtask

  task automatic t_cond_fall();
    for (int p = 0; p < 8; p++) begin
      run(2'b01, 8'(1 << p), 3'(p), 1'b0, 16'hCAFE, 2'd0, 16'(16'h0300 + p));
      chk("R4 cond fall pol=0", 16'(16'h0302 + p), 1'b0);
      run(2'b01, ~8'(1 << p), 3'(p), 1'b1, 16'hCAFE, 2'd0, 16'(16'h0400 + p));
      chk("R4 cond fall pol=1", 16'(16'h0402 + p), 1'b0);
    end
    run(2'b01, 8'h00, 3'd7, 1'b1, 16'h1234, 2'd0, 16'hFFFF);
    chk("R9 cond fall wrap", 16'h0001, 1'b0);
  endtask

  task automatic t_abs();
    run(2'b10, 8'h00, 3'd0, 1'b0, 16'hFFFF, 2'd0, 16'h0010);
    chk("R5 abs top", 16'hFFFF, 1'b1);
    run(2'b10, 8'hFF, 3'd3, 1'b1, 16'h0000, 2'd0, 16'h0020);
    chk("R5 abs zero", 16'h0000, 1'b1);
    run(2'b10, 8'h5A, 3'd1, 1'b0, 16'h1234, 2'd3, 16'h0030);
    chk("R5 abs mid", 16'h1234, 1'b1);
  endtask

  task automatic t_idx();
    idx_regs = {16'h4DDD, 16'h3CCC, 16'h2BBB, 16'h1AAA};
    for (int k = 0; k < 4; k++) begin
      run(2'b11, 8'h00, 3'd0, 1'b1, 16'h9999, 2'(k), 16'h0500);
      chk("R6 idx slot", idx_regs[k*16 +: 16], 1'b1);
    end
  endtask

  task automatic t_none();
    run(2'b00, 8'hFF, 3'd0, 1'b1, 16'h7777, 2'd1, 16'h0600);
    chk("R7 seq step", 16'h0601, 1'b0);
    run(2'b00, 8'h00, 3'd0, 1'b0, 16'h7777, 2'd2, 16'hFFFF);
    chk("R9 seq wrap", 16'h0000, 1'b0);
  endtask

  task automatic t_hold();
    run(2'b10, 8'h00, 3'd0, 1'b0, 16'hBEEF, 2'd0, 16'h0700);
    chk("R8 setup", 16'hBEEF, 1'b1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      form = 2'(i); abs_tgt = 16'(16'h1111 * (i + 1));
      cur_pc = 16'(16'h2222 * (i + 1)); reg_val = 8'(i); exec_en = 1'b0;
      @(negedge clk);
      chk("R8 hold", 16'hBEEF, 1'b1);
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: pc=%h taken=%b expected completion", next_pc, taken);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_cond_taken();
    t_cond_fall();
    t_abs();
    t_idx();
    t_none();
    t_hold();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule